// File: doc/BRIEF.md
# Card Receive Data FIFO with Status Flags and Interrupt Combiner

This block buffers 32-bit words that arrive from a card's serial data receiver until a bus master or a DMA engine collects them. It holds up to sixteen words in arrival order. It reports its fill level on five flags: full, empty, half-full, data-available, and a sticky overrun error. The half-full flag is also driven out as a DMA request, so a transfer can start once half the FIFO holds data.

The five FIFO flags are joined with a few external status bits into one status vector. An interrupt mask register selects bits of that vector, and the selected bits are OR-reduced into one interrupt request. Overrun is the only flag that holds its value. Once set, it stays set until software writes a 1 to the overrun bit of a write-only clear register.

Fill tracking is built around a four-state occupancy machine that runs beside a 5-bit counter. Its states are OCC_EMPTY (no words), OCC_LOW (1 to 7 words), OCC_HIGH (8 to 15 words) and OCC_FULL (16 words). The transitions are:
- OCC_EMPTY to OCC_LOW on an accepted write.
- OCC_LOW to OCC_EMPTY when the last word leaves.
- OCC_LOW to OCC_HIGH when the count reaches 8.
- OCC_HIGH to OCC_LOW when the count drops below 8.
- OCC_HIGH to OCC_FULL when the count reaches 16.
- OCC_FULL to OCC_HIGH on an accepted read.

All flags are decoded from this registered state, so none of them glitches.

Top module: `crx_fifo`

## Requirements
- R1: After reset, `cnt` is 0, `empty` and `avail_n`... see below; precisely: `empty`=1, `avail`=0, `full`=0, `half`=0, `dma_req`=0, `overrun`=0, `rd_data`=0, the mask is all zeros and `irq`=0.
- R2: Words leave in the order they were written. A read accepted at a clock edge presents its word on `rd_data` right after that edge.
- R3: `cnt` ranges from 0 to 16. `full` is 1 exactly when `cnt`=16, and `empty` is 1 exactly when `cnt`=0. Both update at the edge that changes the count.
- R4: `half` and `dma_req` are both 1 exactly when `cnt` is 8 or more.
- R5: `avail` is always the inverse of `empty`.
- R6: A write presented while `full`=1 is dropped. `overrun` goes to 1 after that edge, and the stored words and their order are unchanged.
- R7: A write and a read presented together while `full`=1 count as an overrun. The read proceeds, the write is dropped, and `cnt` becomes 15.
- R8: A read presented while `empty`=1 leaves `rd_data` and `cnt` unchanged and does not set `overrun`.
- R9: `overrun` stays 1 until an edge with `clr_we`=1 and `clr_wdata[0]`=1. A write with `clr_wdata[0]`=0, or `clr_wdata[0]`=1 without `clr_we`, has no effect on it.
- R10: If an overrun and a clear of `overrun` fall on the same edge, `overrun` stays 1.
- R11: `irq` = OR over i of (status[i] AND mask[i]). The status bit positions are: 0 full, 1 empty, 2 half, 3 avail, 4 overrun, 5 and up `ext_stat`.
- R12: An edge with `mask_we`=1 loads `mask_wdata` into the mask. `irq` reflects the new mask right after that edge.
- R13: A write and a read presented together while the FIFO holds between 1 and 15 words leave `cnt` unchanged and keep both streams in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Receiver presents a word this cycle |
| wr_data | input | 32 | Word from the receiver |
| rd_en | input | 1 | Reader pops one word this cycle |
| rd_data | output | 32 | Most recently popped word |
| cnt | output | 5 | Number of words held, 0 to 16 |
| full | output | 1 | All 16 entries hold data |
| empty | output | 1 | No entry holds data |
| half | output | 1 | 8 or more entries hold data |
| avail | output | 1 | At least one word is available |
| overrun | output | 1 | Sticky: a word was dropped |
| dma_req | output | 1 | DMA request, equal to the half-full condition |
| clr_we | input | 1 | Strobe for the write-only clear register |
| clr_wdata | input | 1 | Clear bits; bit 0 clears overrun |
| mask_we | input | 1 | Strobe for the interrupt mask register |
| mask_wdata | input | 7 | New mask, one bit per status position |
| ext_stat | input | 2 | Other status bits joined into the interrupt |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the FIFO one word at a time from empty to full and drains it again, checking every flag at every count. A flag decoded at the wrong threshold, such as half-full at 7 or full at 15, shows up at one exact count.

It pushes writes while the FIFO is full, both alone and together with a read. A design that checked the read first would accept the word and never raise overrun, and a design that let the word through would corrupt the drained order. It also races a clear against a new overrun on the same edge, where a wrong priority loses the error, and reads from an empty FIFO, where a wrong design would step the read pointer and return stale data later.

Finally, it sweeps every mask value over several fill states with external bits applied. A miswired status position raises `irq` for the wrong mask.

// File: rtl/crx_pkg.sv
package crx_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_LOW   = 2'd1,
        OCC_HIGH  = 2'd2,
        OCC_FULL  = 2'd3
    } occ_state_t;

    localparam int ST_FULL    = 0;
    localparam int ST_EMPTY   = 1;
    localparam int ST_HALF    = 2;
    localparam int ST_AVAIL   = 3;
    localparam int ST_OVERRUN = 4;
    localparam int ST_FIFO_N  = 5;

endpackage

// File: rtl/crx_store.sv
module crx_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_go,
    input  logic [AW-1:0]    wptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_go,
    input  logic [AW-1:0]    rptr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_go) begin
            rd_q <= mem[rptr];
        end
    end

    assign rd_data = rd_q;

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));

endmodule

// File: rtl/crx_occ.sv
module crx_occ
    import crx_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int HALF = DEPTH / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          rd_en,
    output logic          wr_go,
    output logic          rd_go,
    output logic          ovr_evt,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty,
    output logic          half
);

    occ_state_t    state_q, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [AW-1:0] wptr_q, rptr_q;

    // Write is judged against the registered full state before the read frees space.
    always_comb begin
        ovr_evt = wr_valid && (state_q == OCC_FULL);
        wr_go   = wr_valid && (state_q != OCC_FULL);
        rd_go   = rd_en && (state_q != OCC_EMPTY);
    end

    always_comb begin
        cnt_n = cnt_q;
        if (wr_go && !rd_go) begin
            cnt_n = cnt_q + 1'b1;
        end else if (rd_go && !wr_go) begin
            cnt_n = cnt_q - 1'b1;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            OCC_EMPTY: begin
                if (wr_go) state_n = OCC_LOW;
            end
            OCC_LOW: begin
                if (cnt_n == '0)                  state_n = OCC_EMPTY;
                else if (cnt_n >= CW'(HALF))      state_n = OCC_HIGH;
            end
            OCC_HIGH: begin
                if (cnt_n == CW'(DEPTH))          state_n = OCC_FULL;
                else if (cnt_n < CW'(HALF))       state_n = OCC_LOW;
            end
            OCC_FULL: begin
                if (rd_go) state_n = OCC_HIGH;
            end
            default: state_n = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
        end else begin
            state_q <= state_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            cnt_q <= cnt_n;
            if (wr_go) begin
                wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
            end
            if (rd_go) begin
                rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
            end
        end
    end

    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        half  = 1'b0;
        unique case (state_q)
            OCC_EMPTY: empty = 1'b1;
            OCC_LOW:   ;
            OCC_HIGH:  half = 1'b1;
            OCC_FULL: begin
                full = 1'b1;
                half = 1'b1;
            end
            default: empty = 1'b1;
        endcase
    end

    assign cnt  = cnt_q;
    assign wptr = wptr_q;
    assign rptr = rptr_q;

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));

    // R3
    full_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full == (cnt_q == CW'(DEPTH)));

    // R3
    empty_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty == (cnt_q == '0));

    // R4
    half_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half == (cnt_q >= CW'(HALF)));

    // R6
    drop_wptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> $stable(wptr_q));

    // R7
    full_rw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_valid && rd_en) |=> (cnt_q == CW'(DEPTH - 1)));

    // R8
    empty_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rptr_q));

endmodule

// File: rtl/crx_flag.sv
module crx_flag
    import crx_pkg::*;
#(
    parameter int  NEXT  = 2,
    localparam int NSTAT = ST_FIFO_N + NEXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovr_evt,
    input  logic             clr_we,
    input  logic             clr_wdata,
    input  logic             mask_we,
    input  logic [NSTAT-1:0] mask_wdata,
    input  logic             full,
    input  logic             empty,
    input  logic             half,
    input  logic [NEXT-1:0]  ext_stat,
    output logic             avail,
    output logic             overrun,
    output logic             irq
);

    logic             ovr_q;
    logic [NSTAT-1:0] mask_q;
    logic [NSTAT-1:0] stat;
    logic             clr_hit;

    assign clr_hit = clr_we && clr_wdata;
    assign avail   = ~empty;

    // A new overrun takes priority over a clear on the same edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (ovr_evt) begin
            ovr_q <= 1'b1;
        end else if (clr_hit) begin
            ovr_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_we) begin
            mask_q <= mask_wdata;
        end
    end

    always_comb begin
        stat              = '0;
        stat[ST_FULL]     = full;
        stat[ST_EMPTY]    = empty;
        stat[ST_HALF]     = half;
        stat[ST_AVAIL]    = avail;
        stat[ST_OVERRUN]  = ovr_q;
        for (int i = 0; i < NEXT; i++) begin
            stat[ST_FIFO_N + i] = ext_stat[i];
        end
    end

    assign irq     = |(stat & mask_q);
    assign overrun = ovr_q;

    // R9
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_q && !clr_hit) |=> ovr_q);

    // R10
    ovr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> ovr_q);

    // R5
    avail_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({avail, empty}));

    // R12
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && mask_wdata == '0) |=> !irq);

endmodule

// File: rtl/crx_fifo.sv
module crx_fifo
    import crx_pkg::*;
#(
    parameter int  WIDTH = 32,
    parameter int  DEPTH = 16,
    parameter int  NEXT  = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int NSTAT = ST_FIFO_N + NEXT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic [CW-1:0]    cnt,
    output logic             full,
    output logic             empty,
    output logic             half,
    output logic             avail,
    output logic             overrun,
    output logic             dma_req,
    input  logic             clr_we,
    input  logic             clr_wdata,
    input  logic             mask_we,
    input  logic [NSTAT-1:0] mask_wdata,
    input  logic [NEXT-1:0]  ext_stat,
    output logic             irq
);

    logic          wr_go, rd_go, ovr_evt;
    logic [AW-1:0] wptr, rptr;

    crx_occ #(.DEPTH(DEPTH)) u_occ (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .rd_en    (rd_en),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .ovr_evt  (ovr_evt),
        .wptr     (wptr),
        .rptr     (rptr),
        .cnt      (cnt),
        .full     (full),
        .empty    (empty),
        .half     (half)
    );

    crx_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_go   (wr_go),
        .wptr    (wptr),
        .wr_data (wr_data),
        .rd_go   (rd_go),
        .rptr    (rptr),
        .rd_data (rd_data)
    );

    crx_flag #(.NEXT(NEXT)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovr_evt    (ovr_evt),
        .clr_we     (clr_we),
        .clr_wdata  (clr_wdata),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .full       (full),
        .empty      (empty),
        .half       (half),
        .ext_stat   (ext_stat),
        .avail      (avail),
        .overrun    (overrun),
        .irq        (irq)
    );

    assign dma_req = half;

    // R4
    dma_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req == (cnt >= CW'(DEPTH / 2)));

endmodule

// File: tb/sim_crx_fifo.sv
`timescale 1ns/1ps
module sim_crx_fifo;

    localparam int DEPTH = 16;
    localparam int NEXT  = 2;
    localparam int NSTAT = 5 + NEXT;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_valid = 1'b0;
    logic [31:0]      wr_data = '0;
    logic             rd_en = 1'b0;
    logic [31:0]      rd_data;
    logic [4:0]       cnt;
    logic             full, empty, half, avail, overrun, dma_req, irq;
    logic             clr_we = 1'b0;
    logic             clr_wdata = 1'b0;
    logic             mask_we = 1'b0;
    logic [NSTAT-1:0] mask_wdata = '0;
    logic [NEXT-1:0]  ext_stat = '0;

    always #4 clk = ~clk;

    crx_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .cnt(cnt), .full(full),
        .empty(empty), .half(half), .avail(avail), .overrun(overrun),
        .dma_req(dma_req), .clr_we(clr_we), .clr_wdata(clr_wdata),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .ext_stat(ext_stat),
        .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mq[$];
    logic [31:0] m_rd = '0;
    logic        m_ovr = 1'b0;
    logic [NSTAT-1:0] m_mask = '0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit w, input logic [31:0] d, input bit r,
                       input bit cw, input bit cd);
        bit ovr;
        wr_valid = w; wr_data = d; rd_en = r; clr_we = cw; clr_wdata = cd;
        @(posedge clk);
        #1;
        wr_valid = 0; rd_en = 0; clr_we = 0; clr_wdata = 0;
        ovr = w && (mq.size() == DEPTH);
        if (r && mq.size() > 0) m_rd = mq.pop_front();
        if (w && !ovr) mq.push_back(d);
        if (ovr) m_ovr = 1;
        else if (cw && cd) m_ovr = 0;
    endtask

    task automatic flags(input string tag);
        int s;
        s = mq.size();
        chk({tag, " R3 cnt"},     32'(cnt), 32'(s));
        chk({tag, " R3 full"},    32'(full), 32'(s == DEPTH));
        chk({tag, " R3 empty"},   32'(empty), 32'(s == 0));
        chk({tag, " R4 half"},    32'(half), 32'(s >= DEPTH / 2));
        chk({tag, " R4 dma_req"}, 32'(dma_req), 32'(s >= DEPTH / 2));
        chk({tag, " R5 avail"},   32'(avail), 32'(s != 0));
        chk({tag, " R9 overrun"}, 32'(overrun), 32'(m_ovr));
        chk({tag, " R2 rd_data"}, rd_data, m_rd);
    endtask

    function automatic logic exp_irq();
        logic [NSTAT-1:0] st;
        int s;
        s = mq.size();
        st = '0;
        st[0] = (s == DEPTH);
        st[1] = (s == 0);
        st[2] = (s >= DEPTH / 2);
        st[3] = (s != 0);
        st[4] = m_ovr;
        for (int i = 0; i < NEXT; i++) st[5 + i] = ext_stat[i];
        return |(st & m_mask);
    endfunction

    task automatic mask_sweep(input string tag);
        for (int m = 0; m < (1 << NSTAT); m++) begin
            for (int e = 0; e < (1 << NEXT); e++) begin
                mask_we = 1; mask_wdata = NSTAT'(m); ext_stat = NEXT'(e);
                @(posedge clk);
                #1;
                mask_we = 0;
                m_mask = NSTAT'(m);
                chk({tag, " R11 R12 irq"}, 32'(irq), 32'(exp_irq()));
            end
        end
        mask_we = 1; mask_wdata = '0; ext_stat = '0;
        @(posedge clk);
        #1;
        mask_we = 0; m_mask = '0;
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1;
        // R1 reset state
        flags("R1 reset");
        chk("R1 irq", 32'(irq), 32'd0);

        // R8 read while empty
        cyc(0, 0, 1, 0, 0);
        flags("R8 empty read");

        // fill sweep R3 R4 R5
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1, 32'hA500_0000 + 32'(i), 0, 0, 0);
            flags("fill");
        end
        mask_sweep("full");

        // R6 write while full
        cyc(1, 32'hDEAD_0001, 0, 0, 0);
        flags("R6 drop");

        // R9 clear without strobe / with zero data: no effect
        cyc(0, 0, 0, 0, 1);
        flags("R9 no strobe");
        cyc(0, 0, 0, 1, 0);
        flags("R9 zero data");

        // R10 overrun and clear together
        cyc(1, 32'hDEAD_0002, 0, 1, 1);
        flags("R10 race");

        // R9 proper clear
        cyc(0, 0, 0, 1, 1);
        flags("R9 clear");

        // R7 read+write while full
        cyc(1, 32'hDEAD_0003, 1, 0, 0);
        flags("R7 full rw");
        cyc(0, 0, 0, 1, 1);
        flags("R7 clear");

        // R13 simultaneous at partial fill
        for (int i = 0; i < 6; i++) begin
            cyc(1, 32'hB700_0000 + 32'(i), 1, 0, 0);
            flags("R13 rw");
        end
        mask_sweep("high");

        // drain, R2 order
        while (mq.size() > 0) begin
            cyc(0, 0, 1, 0, 0);
            flags("R2 drain");
            if (mq.size() == 3) mask_sweep("low");
        end
        cyc(0, 0, 1, 0, 0);
        flags("R8 empty read after drain");
        mask_sweep("empty");

        // write+read together while empty: write only
        cyc(1, 32'hC300_0001, 1, 0, 0);
        flags("R8 empty rw");
        cyc(0, 0, 1, 0, 0);
        flags("R2 single");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule